// File: doc/BRIEF.md
# Video Controller Status Register

This block holds the status byte of a raster video controller. The byte carries three sticky flags: one for the end of a displayed frame, one for a sprite collision, and one that says a scan line held too many sprites. Its low bits hold the index of the sprite that caused the too-many-sprites condition. The rendering logic raises the flags with single-cycle event pulses. The CPU reads the byte with a read strobe, and that read clears all three flags. The end-of-frame flag also drives an active-low interrupt line, which is gated by an interrupt-enable control bit.

Reading the status byte and clearing it happen in the same cycle, so a plain clear-on-read register can lose an event that arrives during that cycle. This design merges the clear and the set in one next-state expression. The set always wins, so an event in the read cycle is never lost. The read returns the value from before the event, and the event's flag stays set for the next read.

Top module: `vid_status_reg`

## Requirements
- R1: A one-cycle `frameEnd` pulse sets the end-of-frame flag, status bit 7, on the next clock edge. The flag stays set until a read clears it.
- R2: A `collideEvt` pulse sets status bit 5 and a `fifthEvt` pulse sets status bit 6, each on the next clock edge. Both stay set until a read clears them.
- R3: In the cycle where `readStrobe` is high, `statusByte` shows the flags as they stood before that edge. After the edge, bits 7, 6 and 5 are zero unless an event arrived in the read cycle.
- R4: An event that arrives in the same cycle as `readStrobe` does not appear in the byte returned by that read. Its flag is set after the edge, so the next read sees it.
- R5: Status bits 4..0 load `fifthIdx` on a `fifthEvt` only when the fifth-sprite flag is clear after any same-cycle read clear. While that flag stays set, those bits do not change.
- R6: `irqN` is low exactly while the end-of-frame flag is set and `intEnable` is high. Dropping `intEnable` releases `irqN` and leaves bit 7 unchanged.
- R7: While and after reset, and before any event, `statusByte` is 0x00 and `irqN` is high.
- R8: A read does not change status bits 4..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameEnd | input | 1 | One-cycle pulse at the end of active display |
| collideEvt | input | 1 | One-cycle pulse when two sprites overlap |
| fifthEvt | input | 1 | One-cycle pulse when a line holds too many sprites |
| fifthIdx | input | 5 | Index of the sprite that caused `fifthEvt` |
| intEnable | input | 1 | Interrupt-enable control bit |
| readStrobe | input | 1 | CPU read of the status byte; clears the flags at the edge |
| statusByte | output | 8 | Status byte: {frame, fifth, collide, index[4:0]} |
| irqN | output | 1 | Interrupt request, active low |

## Verification
Every flag and index update reaches `statusByte` one clock edge after the event or read that caused it. `irqN` follows the frame flag and `intEnable` in the same cycle, with no extra register. The bench drives its inputs at the falling edge. It compares the outputs at the next falling edge with a model that has been advanced by exactly one edge. The value a read returns is compared before that edge, against the model's pre-edge state.

// File: rtl/vid_status_pkg.sv
package vid_status_pkg;

  // Positions inside the three-bit flag vector. The status byte places it
  // above the index field as {frame, fifth, collide}.
  localparam int FLAG_COLLIDE = 0;
  localparam int FLAG_FIFTH   = 1;
  localparam int FLAG_FRAME   = 2;
  localparam int FLAG_COUNT   = 3;

  typedef struct packed {
    logic clearFlags;
    logic setFrame;
    logic setCollide;
    logic setFifth;
    logic loadIdx;
  } statusCtl_t;

endpackage

// File: rtl/vid_status_ctrl.sv
module vid_status_ctrl
  import vid_status_pkg::*;
(
  input  logic       readStrobe,
  input  logic       frameEnd,
  input  logic       collideEvt,
  input  logic       fifthEvt,
  input  logic       fifthFlag,
  input  logic       frameFlag,
  input  logic       intEnable,
  output statusCtl_t ctl,
  output logic       irqN
);

  // A flag that is cleared by this read counts as clear, so the index can
  // reload in the same edge that the flag is set again.
  logic fifthFreeAfterClear;

  always_comb begin
    fifthFreeAfterClear = readStrobe | ~fifthFlag;
    ctl.clearFlags = readStrobe;
    ctl.setFrame   = frameEnd;
    ctl.setCollide = collideEvt;
    ctl.setFifth   = fifthEvt;
    ctl.loadIdx    = fifthEvt & fifthFreeAfterClear;
    irqN           = ~(frameFlag & intEnable);
  end

endmodule

// File: rtl/vid_status_dp.sv
module vid_status_dp
  import vid_status_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  statusCtl_t       ctl,
  input  logic [IDX_W-1:0] fifthIdx,
  output logic [FLAG_COUNT-1:0] flags,
  output logic [IDX_W-1:0] idxReg
);

  logic [FLAG_COUNT-1:0] setVec;
  logic [FLAG_COUNT-1:0] keptVec;
  logic [FLAG_COUNT-1:0] flagsNext;

  always_comb begin
    setVec               = '0;
    setVec[FLAG_COLLIDE] = ctl.setCollide;
    setVec[FLAG_FIFTH]   = ctl.setFifth;
    setVec[FLAG_FRAME]   = ctl.setFrame;
    keptVec              = ctl.clearFlags ? '0 : flags;
    // Set has priority over the read clear, so no event is lost.
    flagsNext            = keptVec | setVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags  <= '0;
      idxReg <= '0;
    end else begin
      flags <= flagsNext;
      if (ctl.loadIdx) idxReg <= fifthIdx;
    end
  end

endmodule

// File: rtl/vid_status_reg.sv
module vid_status_reg
  import vid_status_pkg::*;
#(
  parameter int IDX_W = 5,
  localparam int STATUS_W = IDX_W + FLAG_COUNT
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                frameEnd,
  input  logic                collideEvt,
  input  logic                fifthEvt,
  input  logic [IDX_W-1:0]    fifthIdx,
  input  logic                intEnable,
  input  logic                readStrobe,
  output logic [STATUS_W-1:0] statusByte,
  output logic                irqN
);

  statusCtl_t            ctl;
  logic [FLAG_COUNT-1:0] flags;
  logic [IDX_W-1:0]      idxReg;

  vid_status_ctrl u_ctrl (
    .readStrobe (readStrobe),
    .frameEnd   (frameEnd),
    .collideEvt (collideEvt),
    .fifthEvt   (fifthEvt),
    .fifthFlag  (flags[FLAG_FIFTH]),
    .frameFlag  (flags[FLAG_FRAME]),
    .intEnable  (intEnable),
    .ctl        (ctl),
    .irqN       (irqN)
  );

  vid_status_dp #(.IDX_W(IDX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .fifthIdx (fifthIdx),
    .flags    (flags),
    .idxReg   (idxReg)
  );

  assign statusByte = {flags, idxReg};

endmodule

// File: rtl/vid_status_checker.sv
module vid_status_checker #(
  parameter int IDX_W = 5,
  localparam int STATUS_W = IDX_W + 3
) (
  input logic                clk,
  input logic                rstN,
  input logic                frameEnd,
  input logic                collideEvt,
  input logic                fifthEvt,
  input logic                intEnable,
  input logic                readStrobe,
  input logic [STATUS_W-1:0] statusByte,
  input logic                irqN
);

  localparam int FRAME_POS   = STATUS_W - 1;
  localparam int FIFTH_POS   = STATUS_W - 2;
  localparam int COLLIDE_POS = STATUS_W - 3;

  assert_frame_set_R1: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> statusByte[FRAME_POS]);

  assert_collide_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[COLLIDE_POS] && !readStrobe) |=> statusByte[COLLIDE_POS]);

  assert_fifth_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    fifthEvt |=> statusByte[FIFTH_POS]);

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !frameEnd && !collideEvt && !fifthEvt)
      |=> (statusByte[STATUS_W-1:IDX_W] == '0));

  assert_event_on_read_kept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && collideEvt) |=> statusByte[COLLIDE_POS]);

  assert_idx_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[FIFTH_POS] && !readStrobe) |=> $stable(statusByte[IDX_W-1:0]));

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> irqN);

  assert_irq_needs_frame_R6: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> statusByte[FRAME_POS]);

  assert_read_keeps_idx_R8: assert property (@(posedge clk) disable iff (!rstN)
    (readStrobe && !fifthEvt) |=> $stable(statusByte[IDX_W-1:0]));

endmodule

bind vid_status_reg vid_status_checker #(.IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameEnd   (frameEnd),
  .collideEvt (collideEvt),
  .fifthEvt   (fifthEvt),
  .intEnable  (intEnable),
  .readStrobe (readStrobe),
  .statusByte (statusByte),
  .irqN       (irqN)
);

// File: tb/vid_status_reg_bench.sv
module vid_status_reg_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameEnd = 1'b0;
  logic       collideEvt = 1'b0;
  logic       fifthEvt = 1'b0;
  logic [4:0] fifthIdx = '0;
  logic       intEnable = 1'b0;
  logic       readStrobe = 1'b0;
  logic [7:0] statusByte;
  logic       irqN;

  int checks = 0;
  int errors = 0;

  // Bench model of the architectural state
  logic [2:0] mFlags = '0;   // {frame, fifth, collide}
  logic [4:0] mIdx = '0;

  always #2 clk = ~clk;

  vid_status_reg u_vid_status_reg (
    .clk(clk), .rstN(rstN), .frameEnd(frameEnd), .collideEvt(collideEvt),
    .fifthEvt(fifthEvt), .fifthIdx(fifthIdx), .intEnable(intEnable),
    .readStrobe(readStrobe), .statusByte(statusByte), .irqN(irqN)
  );

  function automatic logic [7:0] expStatus();
    return {mFlags, mIdx};
  endfunction

  function automatic logic expIrqN(input logic en);
    return ~(mFlags[2] & en);
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge and advance the model by one edge.
  // Then compare the outputs at the next falling edge.
  task automatic cycle(input logic fe, input logic col, input logic fif,
                       input logic [4:0] idx, input logic en, input logic rd,
                       input string tag);
    frameEnd = fe; collideEvt = col; fifthEvt = fif;
    fifthIdx = idx; intEnable = en; readStrobe = rd;
    #0.5;
    if (rd) check("R3 read returns pre-edge value", statusByte, expStatus());
    check("R6 irq before edge", {7'd0, irqN}, {7'd0, expIrqN(en)});
    if (rd) mFlags = '0;
    if (fif && !mFlags[1]) mIdx = idx;
    mFlags = mFlags | {fe, fif, col};
    @(negedge clk);
    check(tag, statusByte, expStatus());
    check("R6 irq after edge", {7'd0, irqN}, {7'd0, expIrqN(en)});
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(negedge clk);
    check("R7 status in reset", statusByte, 8'h00);
    check("R7 irqN in reset", {7'd0, irqN}, 8'h01);
    rstN = 1'b1;
    @(negedge clk);
    check("R7 status after reset", statusByte, 8'h00);

    cycle(1, 0, 0, 0, 1, 0, "R1 frame flag set");
    check("R6 irq low with enable", {7'd0, irqN}, 8'h00);
    cycle(0, 0, 0, 0, 1, 0, "R1 frame flag sticky");
    cycle(0, 0, 0, 0, 0, 0, "R6 disable keeps flag");
    check("R6 irq released by disable", {7'd0, irqN}, 8'h01);
    check("R6 flag kept after disable", statusByte, 8'h80);
    cycle(1, 0, 0, 0, 1, 1, "R4 frame event on read kept");
    check("R4 frame flag after read", statusByte, 8'h80);
    cycle(0, 0, 0, 0, 1, 1, "R3 read clears flags");
    check("R3 flags zero after read", statusByte, 8'h00);
    cycle(0, 1, 0, 0, 1, 0, "R2 collision flag set");
    check("R2 collision bit5", statusByte, 8'h20);
    cycle(0, 0, 1, 5'd7, 1, 0, "R5 index loads when flag clear");
    check("R5 index 7 captured", statusByte, 8'h67);
    cycle(0, 0, 1, 5'd9, 1, 0, "R5 index frozen while set");
    check("R5 index stays 7", statusByte, 8'h67);
    cycle(0, 0, 0, 0, 1, 1, "R8 read keeps index");
    check("R8 index after read", statusByte, 8'h07);
    cycle(0, 0, 1, 5'd3, 1, 0, "R5 reload after clear");
    cycle(0, 0, 1, 5'd21, 1, 1, "R4 fifth on read reloads index");
    check("R4 fifth kept with new index", statusByte, 8'h55);

    for (int i = 0; i < 3000; i++) begin
      logic fe, col, fif, rd, en;
      fe  = ($urandom % 16) == 0;
      col = ($urandom % 8) == 0;
      fif = ($urandom % 8) == 0;
      rd  = ($urandom % 4) == 0;
      en  = ($urandom % 32) != 0;
      cycle(fe, col, fif, 5'($urandom), en, rd, "R2 R4 R5 random mix");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule